// File: doc/BRIEF.md
# Programmable Serial Bit-Rate Generator

This block produces the timing pulses for an asynchronous serial host link running from a 12 MHz reference clock. A host command delivers two bytes: a range code that picks a prescale factor, and an 8-bit rate constant. Together they set the bit period to prescale × (256 − constant) reference cycles. Range code 02h uses a prescale of 16, giving 750000 / (256 − constant) bps. Range code 03h uses a prescale of 2, giving 6000000 / (256 − constant) bps. Range code 07h uses a prescale of 1, giving 12000000 / (256 − constant) bps.

Two pulse streams come out. The first is a one-cycle bit tick at the bit rate. The second is an oversample tick with sixteen pulses in each bit period, for the receiver and transmitter shifters. A load strobe captures a new byte pair into a staging register. An apply pulse then requests the switch. The running divider adopts the staged period only when a bit period closes, so no bit is ever cut short. A status flag is low while a switch is waiting and goes high on the tick where the new rate begins.

Top module: `baud_rate_gen`

## Requirements
- R1: After reset the bit period is 1248 reference cycles (range 02h, constant B2h, nominally 9600 bps), the first bit tick comes 1248 cycles after reset is released, and rate_active is 1.
- R2: With range code 02h the bit period is 16 × (256 − constant) cycles, for example 624 cycles for constant D9h and 4096 cycles for constant 00h.
- R3: With range code 03h the bit period is 2 × (256 − constant) cycles, for example 104 for CCh, 120 for C4h and 6 for FDh.
- R4: With range code 07h the bit period is (256 − constant) cycles, for example 13 for F3h and 1 for FFh.
- R5: A load whose range code is not 02h, 03h or 07h leaves the staged period unchanged, so a later apply keeps the previously staged rate.
- R6: A rate change takes effect only at a bit tick: the bit period in progress when apply arrives completes at its old length, and every later period has the new length.
- R7: The new rate is in force no later than one old bit period after apply, which is always under 12000 cycles (1 ms).
- R8: rate_active is 0 from the cycle after apply until the bit tick that starts the new rate, and it rises in the same cycle as that tick.
- R9: When the bit period N is at least 16, exactly 16 oversample ticks occur per bit period and the last one coincides with the bit tick; when N is a multiple of 16 they are spaced exactly N/16 cycles apart.
- R10: When the bit period N is below 16, the oversample tick is high in every cycle, so it gives N pulses per bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_coef | input | 8 | Range code of the requested rate |
| cfg_const | input | 8 | Rate constant of the requested rate |
| cfg_load | input | 1 | Captures the range code and constant into staging |
| apply | input | 1 | Requests a switch to the staged rate |
| os_tick | output | 1 | Oversample pulse, 16 per bit period |
| bit_tick | output | 1 | One pulse per bit period |
| rate_active | output | 1 | High when no rate switch is waiting |

## Verification
The bench switches between rates in all three ranges. It measures every bit period against the length of the rate that should be running, so a switch taken in the middle of a period shows up as a short or long interval. An unrecognised range code is loaded after a valid one and then applied; a design that stored the invalid code would change rate or go to a zero period. Very short periods of 13, 6 and 1 cycles test the saturated oversample mode, where a design that kept its fractional accumulator would drop pulses. The 4096-cycle period checks that the counter is wide enough and that the switch still lands within 1 ms.

// File: rtl/baud_pkg.sv
package baud_pkg;

  // Reference cycles per bit for a given prescale and rate constant
  function automatic int unsigned span(input int unsigned pre,
                                       input int unsigned k,
                                       input int unsigned cw);
    return pre * ((2 ** cw) - k);
  endfunction

endpackage

// File: rtl/baud_cfg_stage.sv
module baud_cfg_stage #(
  parameter int unsigned CW        = 8,
  parameter int unsigned PW        = 13,
  parameter logic [7:0]  COEF_SLOW = 8'h02,
  parameter logic [7:0]  COEF_MID  = 8'h03,
  parameter logic [7:0]  COEF_FAST = 8'h07,
  parameter int unsigned PRE_SLOW  = 16,
  parameter int unsigned PRE_MID   = 2,
  parameter int unsigned PRE_FAST  = 1,
  parameter int unsigned DEF_N     = 1248
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_coef,
  input  logic [CW-1:0] cfg_const,
  input  logic          cfg_load,
  input  logic          apply,
  input  logic          swap,
  output logic [PW-1:0] staged_n,
  output logic          pending,
  output logic          active
);
  localparam int NR = 3;
  localparam logic [CW-1:0] CODES [NR] = '{CW'(COEF_SLOW), CW'(COEF_MID), CW'(COEF_FAST)};
  localparam int unsigned   PRES  [NR] = '{PRE_SLOW, PRE_MID, PRE_FAST};

  logic [NR-1:0] hit;
  logic [PW-1:0] cand [NR];
  logic [PW-1:0] base;
  logic [PW-1:0] pick;
  logic          coef_ok;

  assign base = PW'(2 ** CW) - PW'(cfg_const);

  genvar gi;
  generate
    for (gi = 0; gi < NR; gi++) begin : g_range
      assign hit[gi]  = (cfg_coef == CODES[gi]);
      assign cand[gi] = base * PW'(PRES[gi]);
    end
  endgenerate

  assign coef_ok = |hit;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NR; i++) begin
      if (hit[i]) pick = cand[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      staged_n <= PW'(DEF_N);
      pending  <= 1'b0;
      active   <= 1'b1;
    end else begin
      if (cfg_load && coef_ok) staged_n <= pick;
      if (apply) begin
        pending <= 1'b1;
        active  <= 1'b0;
      end else if (swap) begin
        pending <= 1'b0;
        active  <= 1'b1;
      end
    end
  end

  // R5: an unknown range code must not disturb the staged period
  p_bad_coef_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_load && !coef_ok) |=> $stable(staged_n));

  // R8: an apply drops the flag on the next cycle
  p_apply_drops_flag_r8: assert property (@(posedge clk) disable iff (rst)
    apply |=> !active);

endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div #(
  parameter int unsigned PW    = 13,
  parameter int unsigned DEF_N = 1248
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pending,
  input  logic [PW-1:0] staged_n,
  output logic [PW-1:0] period_q,
  output logic          at_end,
  output logic          swap,
  output logic          bit_tick_q
);
  logic [PW-1:0] cnt;

  assign at_end = (cnt == '0);
  assign swap   = at_end && pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= PW'(DEF_N - 1);
      period_q   <= PW'(DEF_N);
      bit_tick_q <= 1'b0;
    end else if (at_end) begin
      bit_tick_q <= 1'b1;
      if (pending) begin
        period_q <= staged_n;
        cnt      <= staged_n - PW'(1);
      end else begin
        cnt <= period_q - PW'(1);
      end
    end else begin
      cnt        <= cnt - PW'(1);
      bit_tick_q <= 1'b0;
    end
  end

  // R6: the running period only changes together with a bit tick
  p_period_change_at_tick_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(period_q) |-> bit_tick_q);

  // R6: the countdown never exceeds the running period
  p_count_in_period_r6: assert property (@(posedge clk) disable iff (rst)
    cnt < period_q);

endmodule

// File: rtl/baud_os_dist.sv
module baud_os_dist #(
  parameter int unsigned PW       = 13,
  parameter int unsigned OS_RATIO = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] period,
  input  logic          at_end,
  output logic          os_tick_q
);
  localparam logic [PW-1:0] OS_P = PW'(OS_RATIO);

  logic [PW-1:0] acc;
  logic [PW:0]   sum;
  logic          wide;

  assign wide = (period >= OS_P);
  assign sum  = {1'b0, acc} + (PW+1)'(OS_RATIO);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      os_tick_q <= 1'b0;
    end else if (!wide) begin
      acc       <= '0;
      os_tick_q <= 1'b1;
    end else if (sum >= {1'b0, period}) begin
      os_tick_q <= 1'b1;
      acc       <= at_end ? '0 : PW'(sum - {1'b0, period});
    end else begin
      os_tick_q <= 1'b0;
      acc       <= at_end ? '0 : PW'(sum);
    end
  end

  // R9: the fractional accumulator stays below one bit period
  p_acc_bound_r9: assert property (@(posedge clk) disable iff (rst)
    wide |-> (acc < period));

endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen #(
  parameter int unsigned CW        = 8,
  parameter int unsigned OS_RATIO  = 16,
  parameter logic [7:0]  COEF_SLOW = 8'h02,
  parameter logic [7:0]  COEF_MID  = 8'h03,
  parameter logic [7:0]  COEF_FAST = 8'h07,
  parameter int unsigned PRE_SLOW  = 16,
  parameter int unsigned PRE_MID   = 2,
  parameter int unsigned PRE_FAST  = 1,
  parameter int unsigned DEF_PRE   = 16,
  parameter int unsigned DEF_CONST = 8'hB2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_coef,
  input  logic [CW-1:0] cfg_const,
  input  logic          cfg_load,
  input  logic          apply,
  output logic          os_tick,
  output logic          bit_tick,
  output logic          rate_active
);
  localparam int unsigned PW    = $clog2(PRE_SLOW * (2 ** CW)) + 1;
  localparam int unsigned DEF_N = baud_pkg::span(DEF_PRE, DEF_CONST, CW);

  logic [PW-1:0] staged_n;
  logic [PW-1:0] period_q;
  logic          pending;
  logic          at_end;
  logic          swap;

  baud_cfg_stage #(
    .CW(CW), .PW(PW),
    .COEF_SLOW(COEF_SLOW), .COEF_MID(COEF_MID), .COEF_FAST(COEF_FAST),
    .PRE_SLOW(PRE_SLOW), .PRE_MID(PRE_MID), .PRE_FAST(PRE_FAST),
    .DEF_N(DEF_N)
  ) u_stage (
    .clk(clk), .rst(rst),
    .cfg_coef(cfg_coef), .cfg_const(cfg_const), .cfg_load(cfg_load),
    .apply(apply), .swap(swap),
    .staged_n(staged_n), .pending(pending), .active(rate_active)
  );

  baud_bit_div #(.PW(PW), .DEF_N(DEF_N)) u_div (
    .clk(clk), .rst(rst),
    .pending(pending), .staged_n(staged_n),
    .period_q(period_q), .at_end(at_end), .swap(swap),
    .bit_tick_q(bit_tick)
  );

  baud_os_dist #(.PW(PW), .OS_RATIO(OS_RATIO)) u_os (
    .clk(clk), .rst(rst),
    .period(period_q), .at_end(at_end),
    .os_tick_q(os_tick)
  );

  // R9: every bit boundary is also an oversample boundary
  p_os_with_bit_r9: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> os_tick);

  // R8: the flag only comes back on a bit tick
  p_flag_rises_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(rate_active) |-> bit_tick);

endmodule

// File: tb/baud_rate_gen_test.sv
`timescale 1ns/1ps
module baud_rate_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_coef = '0;
  logic [7:0] cfg_const = '0;
  logic       cfg_load = 1'b0;
  logic       apply = 1'b0;
  logic       os_tick;
  logic       bit_tick;
  logic       rate_active;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    int    n;
    int    os;
    int    act;   // -1: not checked
    bit    even;
    string tag;
  } exp_t;

  exp_t q[$];

  always #2.5 clk = ~clk;

  baud_rate_gen uut (
    .clk(clk), .rst(rst),
    .cfg_coef(cfg_coef), .cfg_const(cfg_const), .cfg_load(cfg_load),
    .apply(apply),
    .os_tick(os_tick), .bit_tick(bit_tick), .rate_active(rate_active)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int got, input int want);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, want);
    end
  endtask

  function automatic int os_per_bit(input int n);
    return (n < 16) ? n : 16;
  endfunction

  // Monitor: measures each bit period and its oversample pulses
  initial begin
    int  cyc = 0;
    int  osn = 0;
    int  gap = 0;
    bit  gap_bad = 1'b0;
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (rst) begin
        cyc = 0; osn = 0; gap = 0; gap_bad = 1'b0;
      end else begin
        cyc++;
        gap++;
        if (os_tick) begin
          osn++;
          if (q.size() > 0 && q[0].even && gap != q[0].n / 16) gap_bad = 1'b1;
          gap = 0;
        end
        if (bit_tick) begin
          if (q.size() > 0) begin
            e = q.pop_front();
            check(cyc == e.n, e.tag, "bit period", cyc, e.n);
            check(osn == e.os, e.tag, "oversample count", osn, e.os);
            if (e.act >= 0)
              check(int'(rate_active) == e.act, "R8", "flag at tick", int'(rate_active), e.act);
            if (e.even)
              check(!gap_bad, "R9", "even oversample spacing", int'(gap_bad), 0);
          end
          cyc = 0; osn = 0; gap_bad = 1'b0;
        end
      end
    end
  end

  task automatic wait_tick();
    do begin
      @(posedge clk); #1;
    end while (!bit_tick);
    @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  // Driver: requests a rate and queues the intervals expected around the switch
  task automatic switch_rate(input logic [7:0] c, input logic [7:0] k,
                             input int n_old, input int n_new, input bit even,
                             input string tag);
    int lat;
    wait_tick();
    q.push_back('{n: n_old, os: os_per_bit(n_old), act: -1, even: 1'b0, tag: "R6"});
    q.push_back('{n: n_new, os: os_per_bit(n_new), act: 1, even: even, tag: tag});
    q.push_back('{n: n_new, os: os_per_bit(n_new), act: 1, even: even, tag: tag});
    cfg_coef = c; cfg_const = k; cfg_load = 1'b1; apply = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0; apply = 1'b0;
    lat = 1;
    if (n_old >= 3) check(rate_active == 1'b0, "R8", "flag after apply", int'(rate_active), 0);
    while (!rate_active) begin
      @(negedge clk);
      lat++;
    end
    check(lat <= n_old && lat < 12000, "R7", "switch latency", lat, n_old);
    drain();
  endtask

  initial begin
    q.push_back('{n: 1248, os: 16, act: 1, even: 1'b1, tag: "R1"});
    q.push_back('{n: 1248, os: 16, act: 1, even: 1'b1, tag: "R1"});
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check(rate_active == 1'b1, "R1", "flag after reset", int'(rate_active), 1);
    check(bit_tick == 1'b0, "R1", "no tick at reset", int'(bit_tick), 0);
    drain();

    switch_rate(8'h02, 8'hD9, 1248, 624, 1'b1, "R2");
    switch_rate(8'h03, 8'hCC, 624, 104, 1'b0, "R3");
    // R5: an unknown range code after a valid one keeps 104
    @(negedge clk);
    cfg_coef = 8'h03; cfg_const = 8'hCC; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    switch_rate(8'h05, 8'h00, 104, 104, 1'b0, "R5");
    switch_rate(8'h07, 8'hF3, 104, 13, 1'b0, "R10");
    switch_rate(8'h03, 8'hFD, 13, 6, 1'b0, "R3");
    switch_rate(8'h02, 8'h00, 6, 4096, 1'b1, "R2");
    switch_rate(8'h03, 8'hC4, 4096, 120, 1'b0, "R9");
    switch_rate(8'h02, 8'hB2, 120, 1248, 1'b1, "R2");
    switch_rate(8'h07, 8'hFF, 1248, 1, 1'b0, "R4");

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule